// File: doc/BRIEF.md
# Flash Storage Host Controller Register and Doorbell Engine

This block is the register front end of a flash storage host controller. Software reaches it through a simple 32-bit register port with a combinational read. It brings the controller up with a write-then-poll enable handshake and reports the controller's fixed capabilities. It issues link-layer commands through a small argument/command register set. It keeps interrupt status that software clears by writing ones, and an enable mask that gates the interrupt line. It also holds the base addresses and run-stop controls of the transfer and task management request lists.

Software launches a transfer request by setting that slot's bit in a 32-bit doorbell. The engine hands rung slots one at a time, lowest index first, to an external executor over a request/done handshake. When the executor reports done, the engine clears the slot's doorbell bit, marks the slot's completion status as successful and raises the transfer-complete interrupt status. Descriptor fetch, frame parsing, the physical link and task management execution all live outside this block.

Top module: `shc_regblock`

## Requirements
- R1: The capability register at offset 0x00 reads transfer slots minus one (31) in bits [4:0], task management slots minus one (7) in bits [18:16], and 1 in bit 24 (64-bit addressing). All other bits read 0.
- R2: Writing 1 to bit 0 of the enable register (0x04) starts internal initialisation. The bit reads 0 until initialisation finishes, then reads 1.
- R3: The status register (0x08) shows UIC-command-ready in bit 3 only while the controller is enabled and no link command is running. A write to the link command register (0x14) while bit 3 is 0 is ignored and sets no interrupt status.
- R4: Writing the link startup code 0x16 to 0x14 completes by setting interrupt status bit 6. Argument 2 (0x1C) then reads 0, and status bits 0 (device present), 1 (transfer list ready), 2 (task list ready) and 3 all read 1.
- R5: Any other link command code completes by setting interrupt status bit 6 with argument 2 reading 1. The link bits of the status register stay as they were.
- R6: Interrupt status (0x0C) is write-one-to-clear: written 1s clear their bits and written 0s leave bits alone. A completion event in the same cycle as a clear wins. With all bits cleared the register reads 0.
- R7: The interrupt enable register (0x10) has one enable per source: 0 transfer done, 1 UIC error, 2 power mode, 3 hibernate exit, 4 hibernate enter, 5 task done, 6 UIC command done, 7 device fatal, 8 controller fatal, 9 system bus fatal, 10 crypto fatal. irq_o is the OR of status AND enable.
- R8: The list base address registers read back as written: transfer list low/high at 0x24/0x28, task list low/high at 0x34/0x38. xl_base_o equals {high, low} of the transfer list. The run-stop bits (bit 0 at 0x2C for transfers, 0x3C for tasks) read back as written.
- R9: Doorbell (0x30) writes are ignored while the transfer run-stop bit is 0. Writing 0 to a doorbell bit never clears it.
- R10: Rung slots are dispatched one at a time, lowest index first. exe_req_o stays high with exe_slot_o unchanged until exe_done_i.
- R11: On exe_done_i the active slot's doorbell bit clears and interrupt status bit 0 is set.
- R12: The completion status of slot n reads at 0x80+4n. It holds 0xF (invalid) from reset and from the cycle the slot is rung, and becomes 0x0 (success) when the slot completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_o | output | 1 | Interrupt line |
| xl_base_o | output | 64 | Transfer request list base address |
| exe_req_o | output | 1 | Request to executor, held until done |
| exe_slot_o | output | 5 | Slot being executed |
| exe_done_i | input | 1 | Executor completion pulse |

## Verification
The bench rings several slots in one write and checks the dispatch order against a queue of expected slots. An encoder that chose the highest index, or one that launched a new slot before the previous done, would pop the wrong slot. It rings a doorbell with run-stop off and writes zeros over a pending slot. A design that ignored run-stop would dispatch an unexpected slot, and one that stored a plain write instead of a set would lose the pending bit. It reads the enable bit straight after the write, to catch a design that echoes the written value. It also runs a non-startup link command, which must fail argument 2 without raising the link status bits. Finally it clears interrupt status with a mix of 0 and 1 bits to catch a plain write.

// File: rtl/shc_pkg.sv
package shc_pkg;

  // Register byte offsets
  localparam logic [7:0] OFS_CAPS      = 8'h00;
  localparam logic [7:0] OFS_ENABLE    = 8'h04;
  localparam logic [7:0] OFS_HSTAT     = 8'h08;
  localparam logic [7:0] OFS_IRQ_STAT  = 8'h0C;
  localparam logic [7:0] OFS_IRQ_EN    = 8'h10;
  localparam logic [7:0] OFS_UIC_CMD   = 8'h14;
  localparam logic [7:0] OFS_UIC_ARG1  = 8'h18;
  localparam logic [7:0] OFS_UIC_ARG2  = 8'h1C;
  localparam logic [7:0] OFS_UIC_ARG3  = 8'h20;
  localparam logic [7:0] OFS_XL_LO     = 8'h24;
  localparam logic [7:0] OFS_XL_HI     = 8'h28;
  localparam logic [7:0] OFS_XL_RUN    = 8'h2C;
  localparam logic [7:0] OFS_XL_DB     = 8'h30;
  localparam logic [7:0] OFS_TL_LO     = 8'h34;
  localparam logic [7:0] OFS_TL_HI     = 8'h38;
  localparam logic [7:0] OFS_TL_RUN    = 8'h3C;

  // Interrupt source positions
  localparam int unsigned IRQ_XFER_DONE   = 0;
  localparam int unsigned IRQ_UIC_ERR     = 1;
  localparam int unsigned IRQ_PWR_MODE    = 2;
  localparam int unsigned IRQ_HIB_EXIT    = 3;
  localparam int unsigned IRQ_HIB_ENTER   = 4;
  localparam int unsigned IRQ_TM_DONE     = 5;
  localparam int unsigned IRQ_UIC_DONE    = 6;
  localparam int unsigned IRQ_DEV_FATAL   = 7;
  localparam int unsigned IRQ_HC_FATAL    = 8;
  localparam int unsigned IRQ_BUS_FATAL   = 9;
  localparam int unsigned IRQ_CRYPTO_FATAL = 10;
  localparam int unsigned IRQ_W           = 11;

  // Completion status codes
  localparam int unsigned OCS_W = 4;
  localparam logic [OCS_W-1:0] OCS_OK      = 4'h0;
  localparam logic [OCS_W-1:0] OCS_INVALID = 4'hF;

  // Link command codes
  localparam logic [7:0] UIC_LINK_START = 8'h16;

  typedef enum logic [0:0] {UIC_IDLE = 1'b0, UIC_BUSY = 1'b1} uic_st_e;

endpackage

// File: rtl/shc_enable_ctl.sv
module shc_enable_ctl #(
  parameter int unsigned INIT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  output logic done_o
);
  localparam int unsigned CW = $clog2(INIT_CYC + 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ld;

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    cnt_d  = cnt_q;
    cnt_ld = 1'b0;
    if (wr_en && !wr_val) begin
      busy_d = 1'b0;
      done_d = 1'b0;
      cnt_d  = '0;
      cnt_ld = 1'b1;
    end else if (wr_en && wr_val && !busy_q && !done_q) begin
      busy_d = 1'b1;
      cnt_d  = CW'(INIT_CYC);
      cnt_ld = 1'b1;
    end else if (busy_q) begin
      cnt_ld = 1'b1;
      if (cnt_q <= CW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (cnt_ld) cnt_q <= cnt_d;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/shc_uic_ctl.sv
module shc_uic_ctl
  import shc_pkg::*;
#(
  parameter int unsigned UIC_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       allow_i,
  input  logic       cmd_we,
  input  logic [7:0] cmd_val,
  output logic       rdy_o,
  output logic       done_o,
  output logic       pass_o,
  output logic       link_o
);
  localparam int unsigned CW = $clog2(UIC_CYC + 1);

  uic_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    code_q;
  logic          code_ld;
  logic          link_q, link_d;

  assign rdy_o  = allow_i && (st_q == UIC_IDLE);
  assign done_o = allow_i && (st_q == UIC_BUSY) && (cnt_q <= CW'(1));
  assign pass_o = (code_q == UIC_LINK_START);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    code_ld = 1'b0;
    if (!allow_i) begin
      st_d  = UIC_IDLE;
      cnt_d = '0;
    end else if (st_q == UIC_IDLE) begin
      if (cmd_we) begin
        st_d    = UIC_BUSY;
        cnt_d   = CW'(UIC_CYC);
        code_ld = 1'b1;
      end
    end else if (cnt_q <= CW'(1)) begin
      st_d  = UIC_IDLE;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_comb begin
    link_d = link_q;
    if (!allow_i)               link_d = 1'b0;
    else if (done_o && pass_o)  link_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= UIC_IDLE;
      cnt_q  <= '0;
      code_q <= '0;
      link_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      link_q <= link_d;
      if (code_ld) code_q <= cmd_val;
    end
  end

  assign link_o = link_q;
endmodule

// File: rtl/shc_doorbell.sv
module shc_doorbell
  import shc_pkg::*;
#(
  parameter int unsigned NSLOT = 32,
  parameter int unsigned SW    = $clog2(NSLOT)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ring_we,
  input  logic [NSLOT-1:0]             ring_val,
  input  logic                         run_i,
  input  logic                         done_i,
  output logic [NSLOT-1:0]             db_o,
  output logic                         req_o,
  output logic [SW-1:0]                slot_o,
  output logic                         cpl_o,
  output logic [NSLOT-1:0][OCS_W-1:0]  ocs_o
);
  logic [NSLOT-1:0]            db_q, db_d, fresh, clr;
  logic                        busy_q, busy_d;
  logic [SW-1:0]               cur_q, pick;
  logic                        launch;
  logic [NSLOT-1:0][OCS_W-1:0] ocs_q;

  // lowest set doorbell bit
  always_comb begin
    pick = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (db_q[i]) pick = SW'(i);
    end
  end

  assign launch = !busy_q && (|db_q);
  assign cpl_o  = busy_q && done_i;
  assign fresh  = (ring_we && run_i) ? (ring_val & ~db_q) : '0;
  assign clr    = cpl_o ? (NSLOT'(1) << cur_q) : '0;

  always_comb begin
    db_d   = (db_q & ~clr) | fresh;
    busy_d = busy_q;
    if (cpl_o)       busy_d = 1'b0;
    else if (launch) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q   <= '0;
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else begin
      db_q   <= db_d;
      busy_q <= busy_d;
      if (launch) cur_q <= pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) ocs_q[s] <= OCS_INVALID;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (fresh[s])    ocs_q[s] <= OCS_INVALID;
        else if (clr[s]) ocs_q[s] <= OCS_OK;
      end
    end
  end

  assign db_o   = db_q;
  assign req_o  = busy_q;
  assign slot_o = cur_q;
  assign ocs_o  = ocs_q;
endmodule

// File: rtl/shc_regblock.sv
module shc_regblock
  import shc_pkg::*;
#(
  parameter int unsigned NSLOT    = 32,
  parameter int unsigned NTM      = 8,
  parameter int unsigned INIT_CYC = 4,
  parameter int unsigned UIC_CYC  = 3,
  parameter int unsigned AW       = 8,
  parameter int unsigned DW       = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [AW-1:0]            reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  output logic                     irq_o,
  output logic [2*DW-1:0]          xl_base_o,
  output logic                     exe_req_o,
  output logic [$clog2(NSLOT)-1:0] exe_slot_o,
  input  logic                     exe_done_i
);
  localparam int unsigned SW = $clog2(NSLOT);
  localparam int unsigned TW = $clog2(NTM);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] ofs);
    return a == AW'(ofs);
  endfunction

  logic wr_en_reg, wr_uic, wr_db, wr_is, wr_ie;
  logic wr_a1, wr_a2, wr_a3, wr_xlo, wr_xhi, wr_xrun, wr_tlo, wr_thi, wr_trun;
  assign wr_en_reg = reg_we && hit(reg_addr, OFS_ENABLE);
  assign wr_uic    = reg_we && hit(reg_addr, OFS_UIC_CMD);
  assign wr_db     = reg_we && hit(reg_addr, OFS_XL_DB);
  assign wr_is     = reg_we && hit(reg_addr, OFS_IRQ_STAT);
  assign wr_ie     = reg_we && hit(reg_addr, OFS_IRQ_EN);
  assign wr_a1     = reg_we && hit(reg_addr, OFS_UIC_ARG1);
  assign wr_a2     = reg_we && hit(reg_addr, OFS_UIC_ARG2);
  assign wr_a3     = reg_we && hit(reg_addr, OFS_UIC_ARG3);
  assign wr_xlo    = reg_we && hit(reg_addr, OFS_XL_LO);
  assign wr_xhi    = reg_we && hit(reg_addr, OFS_XL_HI);
  assign wr_xrun   = reg_we && hit(reg_addr, OFS_XL_RUN);
  assign wr_tlo    = reg_we && hit(reg_addr, OFS_TL_LO);
  assign wr_thi    = reg_we && hit(reg_addr, OFS_TL_HI);
  assign wr_trun   = reg_we && hit(reg_addr, OFS_TL_RUN);

  // sub-blocks
  logic en_done, uic_rdy, uic_done, uic_pass, link_up;
  logic [NSLOT-1:0] db_vec;
  logic xfer_cpl;
  logic [NSLOT-1:0][OCS_W-1:0] slot_ocs;
  logic xl_run_q, tl_run_q;

  shc_enable_ctl #(.INIT_CYC(INIT_CYC)) u_en (
    .clk(clk), .rst_n(rst_core_n),
    .wr_en(wr_en_reg), .wr_val(reg_wdata[0]), .done_o(en_done)
  );

  shc_uic_ctl #(.UIC_CYC(UIC_CYC)) u_uic (
    .clk(clk), .rst_n(rst_core_n), .allow_i(en_done),
    .cmd_we(wr_uic), .cmd_val(reg_wdata[7:0]),
    .rdy_o(uic_rdy), .done_o(uic_done), .pass_o(uic_pass), .link_o(link_up)
  );

  shc_doorbell #(.NSLOT(NSLOT), .SW(SW)) u_db (
    .clk(clk), .rst_n(rst_core_n),
    .ring_we(wr_db), .ring_val(reg_wdata[NSLOT-1:0]),
    .run_i(xl_run_q && en_done), .done_i(exe_done_i),
    .db_o(db_vec), .req_o(exe_req_o), .slot_o(exe_slot_o),
    .cpl_o(xfer_cpl), .ocs_o(slot_ocs)
  );

  // interrupt status / enable
  logic [IRQ_W-1:0] is_q, is_d, ie_q, is_set, is_clr;
  always_comb begin
    is_set = '0;
    is_set[IRQ_XFER_DONE] = xfer_cpl;
    is_set[IRQ_UIC_DONE]  = uic_done;
    is_clr = wr_is ? reg_wdata[IRQ_W-1:0] : '0;
    is_d   = (is_q & ~is_clr) | is_set;
  end

  // argument 2 is shared by software writes and command results
  logic [DW-1:0] arg1_q, arg2_q, arg2_d, arg3_q;
  logic          arg2_ld;
  always_comb begin
    arg2_ld = uic_done || wr_a2;
    arg2_d  = reg_wdata;
    if (uic_done) arg2_d = uic_pass ? '0 : DW'(1);
  end

  logic [DW-1:0] xl_lo_q, xl_hi_q, tl_lo_q, tl_hi_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      is_q     <= '0;
      ie_q     <= '0;
      arg1_q   <= '0;
      arg2_q   <= '0;
      arg3_q   <= '0;
      xl_lo_q  <= '0;
      xl_hi_q  <= '0;
      tl_lo_q  <= '0;
      tl_hi_q  <= '0;
      xl_run_q <= 1'b0;
      tl_run_q <= 1'b0;
    end else begin
      is_q <= is_d;
      if (wr_ie)   ie_q     <= reg_wdata[IRQ_W-1:0];
      if (wr_a1)   arg1_q   <= reg_wdata;
      if (arg2_ld) arg2_q   <= arg2_d;
      if (wr_a3)   arg3_q   <= reg_wdata;
      if (wr_xlo)  xl_lo_q  <= reg_wdata;
      if (wr_xhi)  xl_hi_q  <= reg_wdata;
      if (wr_tlo)  tl_lo_q  <= reg_wdata;
      if (wr_thi)  tl_hi_q  <= reg_wdata;
      if (wr_xrun) xl_run_q <= reg_wdata[0];
      if (wr_trun) tl_run_q <= reg_wdata[0];
    end
  end

  // read-only views
  logic [DW-1:0] caps, hstat;
  always_comb begin
    caps = '0;
    caps[SW-1:0]  = SW'(NSLOT - 1);
    caps[16 +: TW] = TW'(NTM - 1);
    caps[24]      = 1'b1;
    hstat = '0;
    hstat[0] = link_up;
    hstat[1] = link_up;
    hstat[2] = link_up;
    hstat[3] = uic_rdy;
  end

  logic [SW-1:0] rd_slot;
  assign rd_slot = reg_addr[2 +: SW];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[AW-1]) begin
      if (reg_addr[1:0] == 2'b00) reg_rdata = DW'(slot_ocs[rd_slot]);
    end else begin
      case (reg_addr)
        AW'(OFS_CAPS):     reg_rdata = caps;
        AW'(OFS_ENABLE):   reg_rdata = DW'(en_done);
        AW'(OFS_HSTAT):    reg_rdata = hstat;
        AW'(OFS_IRQ_STAT): reg_rdata = DW'(is_q);
        AW'(OFS_IRQ_EN):   reg_rdata = DW'(ie_q);
        AW'(OFS_UIC_ARG1): reg_rdata = arg1_q;
        AW'(OFS_UIC_ARG2): reg_rdata = arg2_q;
        AW'(OFS_UIC_ARG3): reg_rdata = arg3_q;
        AW'(OFS_XL_LO):    reg_rdata = xl_lo_q;
        AW'(OFS_XL_HI):    reg_rdata = xl_hi_q;
        AW'(OFS_XL_RUN):   reg_rdata = DW'(xl_run_q);
        AW'(OFS_XL_DB):    reg_rdata = DW'(db_vec);
        AW'(OFS_TL_LO):    reg_rdata = tl_lo_q;
        AW'(OFS_TL_HI):    reg_rdata = tl_hi_q;
        AW'(OFS_TL_RUN):   reg_rdata = DW'(tl_run_q);
        default:           reg_rdata = '0;
      endcase
    end
  end

  assign irq_o     = |(is_q & ie_q);
  assign xl_base_o = {xl_hi_q, xl_lo_q};
endmodule

// File: rtl/shc_checker.sv
module shc_checker #(
  parameter int unsigned NSLOT = 32,
  parameter int unsigned SW    = 5,
  parameter int unsigned IW    = 11,
  parameter int unsigned AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic             exe_req,
  input logic [SW-1:0]    exe_slot,
  input logic             exe_done,
  input logic [NSLOT-1:0] db,
  input logic [IW-1:0]    irq_st,
  input logic             en_done,
  input logic             uic_rdy,
  input logic             link_up
);
  logic db_write;
  assign db_write = reg_we && (reg_addr == AW'(shc_pkg::OFS_XL_DB));

  a_r10_req_has_bell: assert property (@(posedge clk) disable iff (!rst_n)
    exe_req |-> db[exe_slot]);

  a_r10_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_req && !exe_done) |=> (exe_req && $stable(exe_slot)));

  a_r11_bell_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_req && exe_done && !db_write) |=> !db[$past(exe_slot)]);

  a_r11_cpl_status: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_req && exe_done) |=> irq_st[0]);

  a_r3_uic_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    uic_rdy |-> en_done);

  a_r4_link_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> en_done);
endmodule

bind shc_regblock shc_checker #(
  .NSLOT(NSLOT), .SW(SW), .IW(shc_pkg::IRQ_W), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .exe_req(exe_req_o), .exe_slot(exe_slot_o), .exe_done(exe_done_i),
  .db(db_vec), .irq_st(is_q), .en_done(en_done), .uic_rdy(uic_rdy),
  .link_up(link_up)
);

// File: tb/shc_regblock_tb.sv
module shc_regblock_tb;
  logic        clk, rst_n, reg_we, irq_o, exe_req_o, exe_done_i;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [63:0] xl_base_o;
  logic [4:0]  exe_slot_o;

  int nchk = 0;
  int nerr = 0;
  int unsigned exp_q[$];

  shc_regblock u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
    .xl_base_o(xl_base_o), .exe_req_o(exe_req_o), .exe_slot_o(exe_slot_o),
    .exe_done_i(exe_done_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic poll(input logic [7:0] a, input logic [31:0] mask,
                      input logic [31:0] want, output logic [31:0] last);
    for (int i = 0; i < 200; i++) begin
      rd(a, last);
      if ((last & mask) == want) return;
      @(negedge clk);
    end
  endtask

  // driver: push expected dispatch order, then ring
  task automatic ring(input logic [31:0] mask);
    for (int s = 0; s < 32; s++) if (mask[s]) exp_q.push_back(s);
    wr(8'h30, mask);
  endtask

  // monitor / executor model
  initial begin
    exe_done_i = 1'b0;
    forever begin
      @(negedge clk);
      if (exe_req_o) begin
        if (exp_q.size() == 0) begin
          chk("R9 unexpected dispatch", {59'd0, exe_slot_o}, 64'hFFFF);
        end else begin
          chk("R10 dispatch order", {59'd0, exe_slot_o}, 64'(exp_q.pop_front()));
        end
        repeat (4) @(negedge clk);
        exe_done_i = 1'b1;
        @(negedge clk);
        exe_done_i = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    rd(8'h04, v); chk("R2 reset enable", v, 0);
    rd(8'h08, v); chk("R3 reset hstat", v, 0);
    rd(8'h0C, v); chk("R6 reset irq stat", v, 0);
    chk("R7 reset irq", irq_o, 0);
    chk("R10 reset req", exe_req_o, 0);
    rd(8'h84, v); chk("R12 reset slot status", v, 32'hF);

    rd(8'h00, v); chk("R1 caps", v, 32'h0107_001F);

    // link command before enable is ignored
    wr(8'h14, 32'h16);
    repeat (10) @(negedge clk);
    rd(8'h0C, v); chk("R3 cmd ignored when not ready", v, 0);

    // enable handshake
    wr(8'h04, 32'h1);
    rd(8'h04, v); chk("R2 enable reads 0 while init", v, 0);
    poll(8'h04, 32'h1, 32'h1, v); chk("R2 enable reads 1 after init", v, 1);
    rd(8'h08, v); chk("R3 only uic ready", v, 32'h8);

    // link startup
    wr(8'h10, 32'h41);
    wr(8'h18, 0); wr(8'h1C, 32'h55); wr(8'h20, 0);
    wr(8'h14, 32'h16);
    rd(8'h08, v); chk("R3 busy clears uic ready", v[3], 0);
    poll(8'h0C, 32'h40, 32'h40, v); chk("R4 uic done status", v, 32'h40);
    rd(8'h1C, v); chk("R4 arg2 success", v, 0);
    rd(8'h08, v); chk("R4 hstat after startup", v, 32'hF);
    chk("R7 irq with enable", irq_o, 1);
    wr(8'h0C, 32'h40);
    rd(8'h0C, v); chk("R6 cleared to zero", v, 0);
    chk("R7 irq low after clear", irq_o, 0);

    // other command fails
    wr(8'h14, 32'h01);
    poll(8'h0C, 32'h40, 32'h40, v); chk("R5 other cmd completes", v, 32'h40);
    rd(8'h1C, v); chk("R5 arg2 failure", v, 1);
    rd(8'h08, v); chk("R5 link bits kept", v, 32'hF);
    wr(8'h0C, 32'h0);
    rd(8'h0C, v); chk("R6 zero write keeps", v, 32'h40);
    wr(8'h10, 32'h01);
    chk("R7 masked source", irq_o, 0);
    wr(8'h0C, 32'h7FF);
    rd(8'h0C, v); chk("R6 all clear", v, 0);

    // base registers
    wr(8'h24, 32'hDEAD_B000); wr(8'h28, 32'h0000_0012);
    wr(8'h34, 32'hCAFE_0400); wr(8'h38, 32'h0000_0034);
    rd(8'h24, v); chk("R8 xl lo", v, 32'hDEAD_B000);
    rd(8'h38, v); chk("R8 tl hi", v, 32'h34);
    chk("R8 xl base out", xl_base_o, 64'h0000_0012_DEAD_B000);
    wr(8'h3C, 32'h1);
    rd(8'h3C, v); chk("R8 tl run", v, 1);

    // doorbell while stopped
    wr(8'h30, 32'h5);
    repeat (10) @(negedge clk);
    rd(8'h30, v); chk("R9 ignored when stopped", v, 0);

    wr(8'h2C, 32'h1);
    rd(8'h2C, v); chk("R8 xl run", v, 1);

    // several slots at once
    ring(32'h0000_0224);
    rd(8'h94, v); chk("R12 rung slot invalid", v, 32'hF);
    poll(8'h30, 32'hFFFF_FFFF, 0, v); chk("R11 doorbell drained", v, 0);
    rd(8'h0C, v); chk("R11 xfer done status", v, 32'h1);
    chk("R7 xfer irq", irq_o, 1);
    rd(8'h88, v); chk("R12 slot2 ok", v, 0);
    rd(8'h94, v); chk("R12 slot5 ok", v, 0);
    rd(8'hA4, v); chk("R12 slot9 ok", v, 0);
    rd(8'h8C, v); chk("R12 slot3 untouched", v, 32'hF);
    wr(8'h0C, 32'h1);

    // re-ring and zero write
    ring(32'h4);
    rd(8'h88, v); chk("R12 re-rung invalid", v, 32'hF);
    wr(8'h30, 32'h0);
    rd(8'h30, v); chk("R9 zero write no effect", v, 32'h4);
    poll(8'h30, 32'hFFFF_FFFF, 0, v); chk("R11 slot2 cleared", v, 0);
    rd(8'h88, v); chk("R12 slot2 ok again", v, 0);

    // extreme slots
    ring(32'h8000_0001);
    poll(8'h30, 32'hFFFF_FFFF, 0, v); chk("R11 edge slots cleared", v, 0);
    rd(8'hFC, v); chk("R12 slot31 ok", v, 0);
    repeat (3) @(negedge clk);
    chk("R10 all expected dispatched", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule